// File: doc/BRIEF.md
# Gated Shift Clock Cadence Generator

This block runs in the pixel clock domain of a display data path. While a line's active data window is open, it counts pixel-clock cycles and emits one shift-clock enable pulse for each data set handed to the panel. It emits no pulses at any other time. A mode code selects how many pixels are packed into each pulse: 1, 2, 4, 8 or a fractional 2-2/3. In the fractional mode the spacing between pulses repeats an uneven 3-2-3 cycle pattern, so that eight pixels take eight pixel clocks.

With each pulse the block also gives a data-set strobe, the index of the set within the line, and markers for the first set and the last set of the line. The mode and the per-line pixel count are sampled only while the window is closed, so every line runs from the same configuration and starts at the same cadence phase.

The data-set output is a valid-only stream. It has no ready input and no back-pressure. The downstream shifter must take a set in every cycle in which `set_valid` is high.

Top module: `sclk_cadence_gen`

## Requirements
- R1: `shift_pulse` is high only in the cycle after a clock edge that sampled `line_active` high. It is never high after a cycle in which the window was closed.
- R2: Each data set produces exactly one cycle of `shift_pulse`, with `set_valid` high in the same cycle. `set_index` carries 0 for the first set of a line and rises by one for each following set.
- R3: Mode codes 0, 1, 3 and 4 select 1, 2, 4 and 8 pixels per pulse. In these modes a pulse follows every N-th active cycle of the line, where N is the pixel count of the mode. Codes 5 to 7 behave as code 0. Two pulses in back-to-back cycles occur only at one pixel per pulse.
- R4: Mode code 2 packs 2-2/3 pixels per pulse. The pulse spacing repeats 3, 2, 3 cycles, so pulses follow active cycles 3, 5, 8, 11, 13, 16 and so on.
- R5: The mode code and the pixel count are captured on each clock edge at which `line_active` is low. Changes made while the window is open have no effect on the current line.
- R6: `line_first` is high with the first pulse of a line. `line_last` is high with the pulse at which the pixels delivered so far, counted in thirds of a pixel, reach or exceed the programmed count. An odd count in the two-pixel mode therefore ends on the set that carries the last pixel.
- R7: After the pulse that carries `line_last`, no further pulse occurs until the window has closed and opened again.
- R8: Each opening of the window restarts the cycle counter and the 3-2-3 phase. The first pulse of every line falls at the same offset from the window opening.
- R9: If the window closes part-way through a data set, that partial set produces no pulse.
- R10: While reset is asserted, and in the first cycle after it, all outputs are low and `set_index` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Pixels-per-pulse mode code |
| line_active | input | 1 | High for every pixel-clock cycle of the active data window |
| line_pixels | input | PIX_W | Number of pixels in the line |
| shift_pulse | output | 1 | Gated shift-clock enable, one cycle per data set |
| set_valid | output | 1 | Data-set strobe (valid, no back-pressure) |
| set_index | output | PIX_W | Index of the data set within the line |
| line_first | output | 1 | First data set of the line |
| line_last | output | 1 | Data set that completes the line |

## Verification
The collision that matters is the first-set and last-set markers in one pulse. It is provoked by a line in eight-pixel mode whose pixel count fits in a single set, and judged by both markers showing up at the same pulse position. A second collision is a set completing in the very last cycle of the window. Lines whose window length equals the set boundary show that this pulse still appears, while shorter windows show that an unfinished set is dropped. A table of lines across all modes records, for each line, the pulse count and the positions of the two markers.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int PER_W = 4;

  localparam logic [2:0] MODE_ONE   = 3'd0;
  localparam logic [2:0] MODE_TWO   = 3'd1;
  localparam logic [2:0] MODE_FRAC  = 3'd2;
  localparam logic [2:0] MODE_FOUR  = 3'd3;
  localparam logic [2:0] MODE_EIGHT = 3'd4;

  // cycles in the current data set, minus one
  function automatic logic [PER_W-1:0] period_m1(input logic [2:0] mode,
                                                 input logic [1:0] phase);
    case (mode)
      MODE_TWO:   period_m1 = PER_W'(1);
      MODE_FRAC:  period_m1 = (phase == 2'd1) ? PER_W'(1) : PER_W'(2);
      MODE_FOUR:  period_m1 = PER_W'(3);
      MODE_EIGHT: period_m1 = PER_W'(7);
      default:    period_m1 = PER_W'(0);
    endcase
  endfunction

  // pixels per set, in thirds of a pixel
  function automatic logic [4:0] thirds_per_set(input logic [2:0] mode);
    case (mode)
      MODE_TWO:   thirds_per_set = 5'd6;
      MODE_FRAC:  thirds_per_set = 5'd8;
      MODE_FOUR:  thirds_per_set = 5'd12;
      MODE_EIGHT: thirds_per_set = 5'd24;
      default:    thirds_per_set = 5'd3;
    endcase
  endfunction
endpackage

// File: rtl/sclk_cfg_latch.sv
module sclk_cfg_latch #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_active,
  input  logic [2:0]       mode_sel,
  input  logic [PIX_W-1:0] line_pixels,
  output logic [2:0]       mode_q,
  output logic [PIX_W-1:0] pixels_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      pixels_q <= '0;
    end else if (!line_active) begin
      mode_q   <= mode_sel;
      pixels_q <= line_pixels;
    end
  end
endmodule

// File: rtl/sclk_cadence.sv
module sclk_cadence
  import sclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_active,
  input  logic [2:0] mode_q,
  output logic       set_done
);
  logic [PER_W-1:0] cnt;
  logic [1:0]       phase;
  logic [PER_W-1:0] limit;

  assign limit    = period_m1(mode_q, phase);
  assign set_done = line_active && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !line_active) begin
      cnt   <= '0;
      phase <= '0;
    end else if (set_done) begin
      cnt   <= '0;
      phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
    end else begin
      cnt <= cnt + PER_W'(1);
    end
  end
endmodule

// File: rtl/sclk_line_track.sv
module sclk_line_track
  import sclk_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_active,
  input  logic             set_done,
  input  logic [2:0]       mode_q,
  input  logic [PIX_W-1:0] pixels_q,
  output logic             pulse_q,
  output logic             first_q,
  output logic             last_q,
  output logic [PIX_W-1:0] index_q
);
  localparam int ACC_W = PIX_W + 2;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_next;
  logic [ACC_W-1:0] target;
  logic [PIX_W-1:0] sets;
  logic             done;
  logic             emit;
  logic             reach;

  assign target   = ({2'b00, pixels_q} << 1) + {2'b00, pixels_q};
  assign acc_next = acc + ACC_W'(thirds_per_set(mode_q));
  assign reach    = (acc_next >= target);
  assign emit     = set_done && !done;

  always_ff @(posedge clk) begin
    if (!rst_n || !line_active) begin
      acc  <= '0;
      sets <= '0;
      done <= 1'b0;
    end else if (emit) begin
      acc  <= acc_next;
      sets <= sets + PIX_W'(1);
      done <= reach;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      index_q <= '0;
    end else begin
      pulse_q <= emit;
      first_q <= emit && (sets == '0);
      last_q  <= emit && reach;
      if (emit) index_q <= sets;
    end
  end
endmodule

// File: rtl/sclk_cadence_gen.sv
module sclk_cadence_gen #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_sel,
  input  logic             line_active,
  input  logic [PIX_W-1:0] line_pixels,
  output logic             shift_pulse,
  output logic             set_valid,
  output logic [PIX_W-1:0] set_index,
  output logic             line_first,
  output logic             line_last
);
  logic [2:0]       mode_q;
  logic [PIX_W-1:0] pixels_q;
  logic             set_done;
  logic             pulse_q;

  sclk_cfg_latch #(.PIX_W(PIX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .line_active(line_active),
    .mode_sel(mode_sel), .line_pixels(line_pixels),
    .mode_q(mode_q), .pixels_q(pixels_q)
  );

  sclk_cadence u_cad (
    .clk(clk), .rst_n(rst_n), .line_active(line_active),
    .mode_q(mode_q), .set_done(set_done)
  );

  sclk_line_track #(.PIX_W(PIX_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .line_active(line_active),
    .set_done(set_done), .mode_q(mode_q), .pixels_q(pixels_q),
    .pulse_q(pulse_q), .first_q(line_first), .last_q(line_last),
    .index_q(set_index)
  );

  assign shift_pulse = pulse_q;
  assign set_valid   = pulse_q;
endmodule

// File: rtl/sclk_cadence_chk.sv
module sclk_cadence_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_active,
  input logic       shift_pulse,
  input logic       line_first,
  input logic       line_last,
  input logic [2:0] mode_q
);
  p_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |-> $past(line_active));

  p_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_pulse && $past(shift_pulse)) |-> (mode_q == 3'd0 || mode_q > 3'd4));

  p_mode_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_active) |-> $stable(mode_q));

  p_first_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_first |-> shift_pulse);

  p_last_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_last |-> shift_pulse);

  p_quiet_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_last |=> !shift_pulse);
endmodule

bind sclk_cadence_gen sclk_cadence_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_active(line_active),
  .shift_pulse(shift_pulse), .line_first(line_first),
  .line_last(line_last), .mode_q(mode_q)
);

// File: tb/test_sclk_cadence_gen.sv
module test_sclk_cadence_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 12;

  typedef struct packed {
    logic [2:0] m;
    int pix;
    int len;
    int n;
    int f;
    int l;
    int req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd0,   5,  8, 5, 1,  5, 3},   // R3 one pixel per pulse
    '{3'd1,   6, 10, 3, 2,  6, 3},   // R3 two pixels
    '{3'd2,   8, 12, 3, 3,  8, 4},   // R4 3-2-3 cadence
    '{3'd2,  16, 20, 6, 3, 16, 4},   // R4 two full cadences
    '{3'd3,  12, 12, 3, 4, 12, 3},   // R3 four pixels, set ends on last active cycle
    '{3'd4,  16, 16, 2, 8, 16, 3},   // R3 eight pixels
    '{3'd2,  10, 12, 4, 3, 11, 6},   // R6 fractional overshoot
    '{3'd1,   7,  8, 4, 2,  8, 6},   // R6 odd count rounds up
    '{3'd3, 100, 10, 2, 4,  0, 9},   // R9 truncated window
    '{3'd5,   3,  4, 3, 1,  3, 3},   // R3 unused code acts as one pixel
    '{3'd4,   8,  8, 1, 8,  8, 6}    // R6 first and last in one pulse
  };

  logic             clk = 0;
  logic             rst_n = 0;
  logic [2:0]       mode_sel = 0;
  logic             line_active = 0;
  logic [PIX_W-1:0] line_pixels = 0;
  logic             shift_pulse, set_valid, line_first, line_last;
  logic [PIX_W-1:0] set_index;

  int checks = 0;
  int errors = 0;
  int idx_bad_total = 0;
  int late_total = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_cadence_gen #(.PIX_W(PIX_W)) i_sclk_cadence_gen (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .line_active(line_active),
    .line_pixels(line_pixels), .shift_pulse(shift_pulse), .set_valid(set_valid),
    .set_index(set_index), .line_first(line_first), .line_last(line_last)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_line(input logic [2:0] m, input int pix, input int len,
                          input int chg_at, input logic [2:0] chg_m,
                          output int n, output int fpos, output int lpos);
    mode_sel = m;
    line_pixels = PIX_W'(pix);
    line_active = 0;
    repeat (2) @(negedge clk);
    n = 0; fpos = 0; lpos = 0;
    line_active = 1;
    for (int t = 1; t <= len + 3; t++) begin
      @(negedge clk);
      if (shift_pulse) begin
        if (int'(set_index) != n || !set_valid) idx_bad_total++;
        if (t > len) late_total++;
        n++;
      end
      if (line_first) begin
        if (fpos == 0) fpos = t; else idx_bad_total++;
      end
      if (line_last) begin
        if (lpos == 0) lpos = t; else idx_bad_total++;
      end
      if (t == chg_at) mode_sel = chg_m;
      if (t == len) line_active = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, f, l;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 pulse in reset", int'(shift_pulse), 0);
    check("R10 markers in reset", int'(line_first | line_last | set_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check("R10 index after reset", int'(set_index), 0);
    check("R10 pulse after reset", int'(shift_pulse), 0);

    for (int i = 0; i < NV; i++) begin
      run_line(VECS[i].m, VECS[i].pix, VECS[i].len, 0, 3'd0, n, f, l);
      check($sformatf("R%0d row %0d pulse count", VECS[i].req, i), n, VECS[i].n);
      check($sformatf("R%0d row %0d first position", VECS[i].req, i), f, VECS[i].f);
      check($sformatf("R%0d row %0d last position", VECS[i].req, i), l, VECS[i].l);
      if (i == 0) check("R7 no pulses beyond last set", n, 5);
    end

    // R5 mode change mid-line ignored: eight-pixel line, code switched to 0
    run_line(3'd4, 16, 16, 2, 3'd0, n, f, l);
    check("R5 count after mid-line mode change", n, 2);
    check("R5 first after mid-line mode change", f, 8);

    // R8 cadence restarts: truncated fractional line, then a fresh line
    run_line(3'd2, 100, 7, 0, 3'd0, n, f, l);
    check("R9 partial set dropped", n, 2);
    run_line(3'd2, 8, 8, 0, 3'd0, n, f, l);
    check("R8 first pulse offset on new line", f, 3);
    check("R8 last pulse on new line", l, 8);

    check("R2 index and strobe sequence", idx_bad_total, 0);
    check("R1 pulses outside window", late_total, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule